// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox Controller

This block lets a group of processor agents signal one another and exchange short messages. Every agent owns a small control bank on a shared memory-mapped bus. A write to that bank's doorbell register names one or more target agents. Each target then holds a pending bit that identifies the sender, and raises its interrupt line if that source is unmasked. The target's software acknowledges by writing the pending bits back to its status register. The sender can poll a per-target busy view to learn whether its last doorbell has been taken.

Alongside the control banks sits a word-wide message RAM. Each buffered agent has a region, and each region is divided into one slot per peer. A slot holds an 8-word request half and an 8-word response half. A sender writes its payload into the slot and then rings the doorbell. Agents above the buffered count take part in doorbell signalling only.

Bus map: when address bit 15 is 0 the access goes to a control bank. Bank `b` sits at `b*0x20`. When bit 15 is 1 the access goes to the message area. Region `r` sits at `0x8000 + r*0x200`, peer slot `k` at `+k*0x40`, the response half at `+0x20`, and word `w` at `+w*4`.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset every pending bit is 0, every mask bit of an implemented agent reads 1 (mask offset 0x14 reads 0xFF with 8 agents), all irq outputs are low, and the doorbell offset 0x00 reads 0.
- R2: Writing 1 to bit N of bank A at offset 0x00 sets bit A of bank N's status (offset 0x10). The change is visible to a read issued in the next cycle. Doorbell bits naming agents that do not exist are dropped, and offset 0x00 always reads 0.
- R3: Bit N of bank A's busy view (offset 0x04) reads 1 exactly while bit A of bank N's status is pending.
- R4: Status is write-one-to-clear. Ones clear exactly the written pending bits, and zeros leave bits unchanged.
- R5: Ringing a doorbell toward a source that is already pending leaves one pending bit, and a single clear removes it.
- R6: Writing ones at offset 0x18 unmasks those sources and writing ones at 0x1C masks them. Zero bits are unaffected in both cases. Mask reads 1 for masked sources, and writes to offset 0x14 have no effect.
- R7: irq[N] is high when some status bit of bank N is pending and unmasked. It follows a status or mask change by one cycle.
- R8: A message word written at the address given by the bus map reads back unchanged from the same address.
- R9: Message addresses in regions at or above the buffered count read 0 and ignore writes, without disturbing any implemented region. Unbuffered agents still ring doorbells and receive them.
- R10: bus_rvalid rises exactly one cycle after every read request. Banks at or above the agent count and the unused offsets 0x08 and 0x0C read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| irq | output | NUM_AGENTS | Per-agent interrupt line |

## Verification
Writes to a bank take effect at the clock edge that accepts them. A read issued on the following cycle therefore already sees the new status, busy or mask value. Read data and bus_rvalid appear one edge after the request, and irq moves one edge after the status or mask change that caused it. The bench keeps a behavioural model that steps on the same edges and compares irq, bus_rvalid and bus_rdata at every falling edge. The directed checks sample those outputs only after the edges listed above have passed.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  // 0x20 bytes per control bank
  localparam int BANK_LSB       = 5;
  // 0x200 bytes per message region
  localparam int MSG_REGION_LSB = 9;
  // words held by one message region
  localparam int REGION_WORDS   = 128;

  typedef enum logic [2:0] {
    REG_DOORBELL = 3'd0,
    REG_BUSY     = 3'd1,
    REG_PENDING  = 3'd4,
    REG_MASK     = 3'd5,
    REG_UNMASK   = 3'd6,
    REG_SETMASK  = 3'd7
  } ctrl_reg_e;

  typedef struct packed {
    logic doorbell;
    logic pending;
    logic unmask;
    logic setmask;
  } ctrl_we_t;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_pkg::*;
#(
  parameter int NUM_AGENTS = 8,
  parameter int NUM_BUF    = 4,
  parameter int ADDR_W     = 16,
  parameter int AG_W       = 3,
  parameter int RAM_AW     = 9
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output ctrl_we_t          ctrl_we,
  output logic              ctrl_re,
  output logic [AG_W-1:0]   bank_sel,
  output logic [2:0]        reg_off,
  output logic              msg_we,
  output logic              msg_re,
  output logic [RAM_AW-1:0] msg_addr
);
  localparam int BANK_FW   = ADDR_W - 1 - BANK_LSB;
  localparam int REGION_FW = ADDR_W - 1 - MSG_REGION_LSB;

  logic [BANK_FW-1:0]   bank_full;
  logic [REGION_FW-1:0] region;
  logic                 bank_ok, region_ok, ctrl_hit, msg_hit, ctrl_wr;
  logic                 unused_low;

  assign bank_full = bus_addr[ADDR_W-2:BANK_LSB];
  assign region    = bus_addr[ADDR_W-2:MSG_REGION_LSB];
  assign bank_ok   = bank_full < BANK_FW'(NUM_AGENTS);
  assign region_ok = region < REGION_FW'(NUM_BUF);
  assign reg_off   = bus_addr[BANK_LSB-1:2];
  assign bank_sel  = bank_full[AG_W-1:0];

  assign ctrl_hit = bus_valid && !bus_addr[ADDR_W-1] && bank_ok;
  assign msg_hit  = bus_valid &&  bus_addr[ADDR_W-1] && region_ok;
  assign ctrl_wr  = ctrl_hit && bus_write;
  assign ctrl_re  = ctrl_hit && !bus_write;

  assign ctrl_we.doorbell = ctrl_wr && (reg_off == REG_DOORBELL);
  assign ctrl_we.pending  = ctrl_wr && (reg_off == REG_PENDING);
  assign ctrl_we.unmask   = ctrl_wr && (reg_off == REG_UNMASK);
  assign ctrl_we.setmask  = ctrl_wr && (reg_off == REG_SETMASK);

  assign msg_we   = msg_hit && bus_write;
  assign msg_re   = msg_hit && !bus_write;
  assign msg_addr = RAM_AW'({region, bus_addr[MSG_REGION_LSB-1:2]});

  assign unused_low = ^bus_addr[1:0];
endmodule

// File: rtl/ipi_agent_bank.sv
module ipi_agent_bank #(
  parameter int NUM_AGENTS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_AGENTS-1:0] set_bits,
  input  logic [NUM_AGENTS-1:0] clr_bits,
  input  logic [NUM_AGENTS-1:0] unmask_bits,
  input  logic [NUM_AGENTS-1:0] mask_bits,
  output logic [NUM_AGENTS-1:0] pending_q,
  output logic [NUM_AGENTS-1:0] mask_q,
  output logic                  irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= '0;
      mask_q    <= '1;
      irq_q     <= 1'b0;
    end else begin
      // a set applied after the clear wins on a shared bit
      pending_q <= (pending_q & ~clr_bits) | set_bits;
      mask_q    <= (mask_q & ~unmask_bits) | mask_bits;
      irq_q     <= |(pending_q & ~mask_q);
    end
  end
endmodule

// File: rtl/ipi_msg_ram.sv
module ipi_msg_ram #(
  parameter int DEPTH  = 512,
  parameter int AW     = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_pkg::*;
#(
  parameter int NUM_AGENTS = 8,
  parameter int NUM_BUF    = 4,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  bus_rvalid,
  output logic [NUM_AGENTS-1:0] irq
);
  localparam int AG_W      = $clog2(NUM_AGENTS);
  localparam int RAM_DEPTH = NUM_BUF * REGION_WORDS;
  localparam int RAM_AW    = $clog2(RAM_DEPTH);

  ctrl_we_t            ctrl_we;
  logic                ctrl_re, msg_we, msg_re;
  logic [AG_W-1:0]     bank_sel;
  logic [2:0]          reg_off;
  logic [RAM_AW-1:0]   msg_addr;

  logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] status_all;
  logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] mask_all;
  logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] busy_all;
  logic [NUM_AGENTS-1:0]                 sender_onehot;

  logic [DATA_W-1:0] ctrl_rd_val, ctrl_rd_q, ram_q;
  logic              rvalid_q, msg_sel_q;

  ipi_addr_decode #(
    .NUM_AGENTS(NUM_AGENTS), .NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W),
    .AG_W(AG_W), .RAM_AW(RAM_AW)
  ) dec_i (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .ctrl_we(ctrl_we), .ctrl_re(ctrl_re), .bank_sel(bank_sel),
    .reg_off(reg_off), .msg_we(msg_we), .msg_re(msg_re), .msg_addr(msg_addr)
  );

  assign sender_onehot = NUM_AGENTS'(1) << bank_sel;

  for (genvar n = 0; n < NUM_AGENTS; n++) begin : g_agent
    logic [NUM_AGENTS-1:0] set_v, clr_v, unmask_v, mask_v;
    logic                  own_bank;

    assign own_bank = (bank_sel == AG_W'(n));
    assign set_v    = (ctrl_we.doorbell && bus_wdata[n]) ? sender_onehot : '0;
    assign clr_v    = (ctrl_we.pending && own_bank) ? bus_wdata[NUM_AGENTS-1:0] : '0;
    assign unmask_v = (ctrl_we.unmask  && own_bank) ? bus_wdata[NUM_AGENTS-1:0] : '0;
    assign mask_v   = (ctrl_we.setmask && own_bank) ? bus_wdata[NUM_AGENTS-1:0] : '0;

    ipi_agent_bank #(.NUM_AGENTS(NUM_AGENTS)) bank_i (
      .clk(clk), .rst(rst),
      .set_bits(set_v), .clr_bits(clr_v),
      .unmask_bits(unmask_v), .mask_bits(mask_v),
      .pending_q(status_all[n]), .mask_q(mask_all[n]), .irq_q(irq[n])
    );

    // busy view: sender n sees target m's pending bit n
    for (genvar m = 0; m < NUM_AGENTS; m++) begin : g_busy
      assign busy_all[n][m] = status_all[m][n];
    end
  end

  ipi_msg_ram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW), .DATA_W(DATA_W)) ram_i (
    .clk(clk), .we(msg_we), .re(msg_re), .addr(msg_addr),
    .wdata(bus_wdata), .rdata(ram_q)
  );

  always_comb begin
    ctrl_rd_val = '0;
    if (ctrl_re) begin
      case (reg_off)
        REG_BUSY:    ctrl_rd_val = DATA_W'(busy_all[bank_sel]);
        REG_PENDING: ctrl_rd_val = DATA_W'(status_all[bank_sel]);
        REG_MASK:    ctrl_rd_val = DATA_W'(mask_all[bank_sel]);
        default:     ctrl_rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q  <= 1'b0;
      msg_sel_q <= 1'b0;
      ctrl_rd_q <= '0;
    end else begin
      rvalid_q  <= bus_valid && !bus_write;
      msg_sel_q <= msg_re;
      ctrl_rd_q <= ctrl_rd_val;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = msg_sel_q ? ram_q : ctrl_rd_q;
endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk #(
  parameter int NUM_AGENTS = 8,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_valid,
  input logic                  bus_write,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic                  bus_rvalid,
  input logic [NUM_AGENTS-1:0] irq,
  input logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] status_all,
  input logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] mask_all
);
  logic       is_ctrl_wr;
  logic [2:0] off;
  int         bank;
  logic       unused_chk;

  assign is_ctrl_wr = bus_valid && bus_write && !bus_addr[ADDR_W-1];
  assign off        = bus_addr[4:2];
  assign bank       = int'(bus_addr[ADDR_W-2:5]);
  assign unused_chk = ^{bus_addr[1:0], bus_wdata};

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (irq == '0 && !bus_rvalid));

  // R10
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> bus_rvalid);

  // R10
  no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> !bus_rvalid);

  for (genvar n = 0; n < NUM_AGENTS; n++) begin : g_t
    for (genvar a = 0; a < NUM_AGENTS; a++) begin : g_s
      // R2
      pending_set_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_all[n][a]) |->
          $past(is_ctrl_wr && off == 3'd0 && bank == a && bus_wdata[n]));
      // R4
      pending_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(status_all[n][a]) |->
          $past(is_ctrl_wr && off == 3'd4 && bank == n && bus_wdata[a]));
      // R6
      unmask_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mask_all[n][a]) |->
          $past(is_ctrl_wr && off == 3'd6 && bank == n && bus_wdata[a]));
      // R6
      setmask_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mask_all[n][a]) |->
          $past(is_ctrl_wr && off == 3'd7 && bank == n && bus_wdata[a]));
    end
  end
endmodule

bind ipi_mailbox ipi_mailbox_chk #(
  .NUM_AGENTS(NUM_AGENTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .irq(irq), .status_all(status_all), .mask_all(mask_all)
);

// File: tb/ipi_mailbox_tb_top.sv
module ipi_mailbox_tb_top;
  localparam int NA = 8;
  localparam int NB = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [31:0] AMASK = 32'h0000_00FF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [AW-1:0] bus_addr  = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic [NA-1:0] irq;

  always #5 clk = ~clk;

  ipi_mailbox #(.NUM_AGENTS(NA), .NUM_BUF(NB), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] pend_m [NA];
  logic [31:0] mask_m [NA];
  logic [31:0] mem_m  [int];
  logic [NA-1:0] irq_m, irq_nx;
  logic [31:0] exp_rd;
  logic        exp_rv;
  string       exp_tag;

  function automatic logic [31:0] model_read(input logic [15:0] a);
    int b, o, r, w;
    logic [31:0] v;
    v = '0;
    if (!a[15]) begin
      b = int'(a[14:0]) >> 5;
      o = (int'(a) >> 2) & 7;
      if (b < NA) begin
        if (o == 1) begin
          for (int n = 0; n < NA; n++) v[n] = pend_m[n][b];
        end else if (o == 4) v = pend_m[b];
        else if (o == 5) v = mask_m[b];
      end
    end else begin
      r = int'(a[14:0]) >> 9;
      w = int'(a[14:0]) >> 2;
      if (r < NB && mem_m.exists(w)) v = mem_m[w];
    end
    return v;
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [31:0] d);
    int b, o, r;
    if (!a[15]) begin
      b = int'(a[14:0]) >> 5;
      o = (int'(a) >> 2) & 7;
      if (b < NA) begin
        case (o)
          0: for (int n = 0; n < NA; n++) if (d[n]) pend_m[n][b] = 1'b1;
          4: pend_m[b] = pend_m[b] & ~d & AMASK;
          6: mask_m[b] = mask_m[b] & ~d & AMASK;
          7: mask_m[b] = (mask_m[b] | d) & AMASK;
          default: ;
        endcase
      end
    end else begin
      r = int'(a[14:0]) >> 9;
      if (r < NB) mem_m[int'(a[14:0]) >> 2] = d;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NA; n++) begin
        pend_m[n] = '0;
        mask_m[n] = AMASK;
      end
      irq_m  = '0;
      exp_rv = 1'b0;
      exp_rd = '0;
    end else begin
      for (int n = 0; n < NA; n++) irq_nx[n] = |(pend_m[n] & ~mask_m[n]);
      exp_rv  = bus_valid && !bus_write;
      exp_rd  = exp_rv ? model_read(bus_addr) : '0;
      exp_tag = bus_addr[15] ? "R8" : "R2";
      if (bus_valid && bus_write) model_write(bus_addr, bus_wdata);
      irq_m = irq_nx;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(irq === irq_m, "R7 model irq", 32'(irq), 32'(irq_m));
      chk(bus_rvalid === exp_rv, "R10 model rvalid", 32'(bus_rvalid), 32'(exp_rv));
      if (exp_rv) chk(bus_rdata === exp_rd, exp_tag, bus_rdata, exp_rd);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    chk(bus_rvalid === 1'b1, req, 32'(bus_rvalid), 32'd1);
    chk(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  task automatic rd_any(input logic [15:0] a);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  function automatic logic [15:0] ca(input int b, input int o);
    return 16'(b * 32 + o);
  endfunction

  function automatic logic [15:0] ma(input int r, input int k, input int h, input int w);
    return 16'(32'h8000 + r * 512 + k * 64 + h * 32 + w * 4);
  endfunction

  initial begin
    #500000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(irq === '0, "R1 irq", 32'(irq), 32'd0);
    rd(ca(0, 'h14), 32'hFF, "R1 mask");
    rd(ca(3, 'h10), 32'h0, "R1 status");
    rd(ca(4, 'h00), 32'h0, "R1 doorbell");
    // R2 doorbell from 2 to 5
    wr(ca(2, 'h00), 32'h20);
    rd(ca(5, 'h10), 32'h04, "R2 status");
    rd(ca(2, 'h00), 32'h0, "R2 doorbell reads zero");
    rd(ca(2, 'h04), 32'h20, "R3 busy");
    chk(irq[5] === 1'b0, "R7 masked", 32'(irq[5]), 32'd0);
    // R6 / R7 unmask
    wr(ca(5, 'h18), 32'h04);
    rd(ca(5, 'h14), 32'hFB, "R6 unmask");
    chk(irq[5] === 1'b1, "R7 raised", 32'(irq[5]), 32'd1);
    // R5 repeat doorbell, second sender
    wr(ca(2, 'h00), 32'h20);
    wr(ca(7, 'h00), 32'h20);
    rd(ca(5, 'h10), 32'h84, "R5 no double count");
    wr(ca(5, 'h10), 32'h04);
    rd(ca(5, 'h10), 32'h80, "R4 w1c");
    rd(ca(2, 'h04), 32'h0, "R3 busy cleared");
    rd(ca(7, 'h04), 32'h20, "R3 busy kept");
    chk(irq[5] === 1'b0, "R7 only masked left", 32'(irq[5]), 32'd0);
    // R6 mask offset ignores writes; setmask
    wr(ca(5, 'h14), 32'h0);
    rd(ca(5, 'h14), 32'hFB, "R6 mask write ignored");
    wr(ca(5, 'h1C), 32'h04);
    rd(ca(5, 'h14), 32'hFF, "R6 setmask");
    // R2 nonexistent targets dropped, self doorbell
    wr(ca(0, 'h00), 32'hFFFF_FF00);
    rd(ca(0, 'h04), 32'h0, "R2 high bits dropped");
    wr(ca(3, 'h00), 32'h08);
    rd(ca(3, 'h10), 32'h08, "R2 self");
    // R10 unmapped
    rd(ca(10, 'h10), 32'h0, "R10 bank out of range");
    rd(ca(3, 'h08), 32'h0, "R10 unused offset");
    // R8 message RAM
    wr(ma(1, 3, 0, 0), 32'hA5A5_0001);
    wr(ma(1, 3, 1, 7), 32'h0000_1234);
    wr(ma(0, 0, 0, 0), 32'h0000_DEAD);
    wr(ma(3, 7, 1, 7), 32'h0000_CAFE);
    rd(ma(1, 3, 0, 0), 32'hA5A5_0001, "R8 request word");
    rd(ma(1, 3, 1, 7), 32'h0000_1234, "R8 response word");
    rd(ma(0, 0, 0, 0), 32'h0000_DEAD, "R8 first word");
    rd(ma(3, 7, 1, 7), 32'h0000_CAFE, "R8 last word");
    // R9 regions without buffer
    wr(ma(5, 3, 0, 0), 32'h0000_0055);
    rd(ma(5, 3, 0, 0), 32'h0, "R9 unbuffered read");
    rd(ma(4, 0, 0, 0), 32'h0, "R9 first unbuffered region");
    rd(ma(1, 3, 0, 0), 32'hA5A5_0001, "R9 no alias");
    wr(ca(6, 'h00), 32'h02);
    rd(ca(1, 'h10), 32'h40, "R9 unbuffered doorbell");
    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      int kind, b, o;
      logic [31:0] d;
      kind = int'($urandom % 5);
      b    = int'($urandom % 10);
      o    = 4 * int'($urandom % 8);
      d    = (($urandom % 4) == 0) ? $urandom : ($urandom & AMASK);
      if (kind == 0) begin
        logic [15:0] m;
        m = ma(int'($urandom % 4), int'($urandom % 8), int'($urandom % 2),
               int'($urandom % 8));
        wr(m, d);
        rd_any(m);
      end else if (kind < 3) wr(ca(b, o), d);
      else rd_any(ca(b, o));
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule